// File: doc/BRIEF.md
# Streaming Correlation Peak Finder

This block takes a correlation surface streamed as packets of complex samples in Cartesian form, one sample per accepted beat, and reduces each packet to a single result. For every beat it forms the squared magnitude, real² + imaginary², and keeps the largest value seen so far in the packet along with that sample's linear position. When the final beat of a packet is accepted, it emits one result beat that carries the peak value and its position. A downstream score comparator or software can then read the result.

Both sides use a valid/ready handshake. A beat moves when valid and ready are both high at a rising clock edge. A result stays on the output, unchanged, until the sink takes it. While a result is waiting and the sink is not ready, the input ready is held low, so the source stalls and no sample is lost. While no result is waiting, or while the waiting result is being taken in the current cycle, the input stays open. This lets the next surface stream in with no bubble. The default surface is 64×64 samples, and the position is reported as row × 64 + column.

Top module: `corr_peak_finder`

## Requirements
- R1: During and right after reset, `m_valid` is low and `s_ready` is high.
- R2: The metric is re² + im², with both inputs treated as signed 16-bit two's complement values. `m_peak` is the exact 33-bit unsigned result, so both inputs at -32768 give 2147483648.
- R3: A later sample replaces the stored peak only if its metric is strictly greater. When metrics are equal, the earlier position is reported.
- R4: The first beat of a packet always loads the stored peak and sets position 0, even if its metric is below the peak of the previous packet.
- R5: `m_index` is the number of beats accepted in the packet before the peak beat (row × 64 + column for a 64×64 surface), 12 bits wide.
- R6: `m_valid` goes high in the cycle right after the beat with `s_eop` is accepted.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_peak` and `m_index` hold their values. After a transfer with no new end of packet accepted, `m_valid` goes low.
- R8: `s_ready` is low exactly when `m_valid` is high and `m_ready` is low. Otherwise it is high.
- R9: The beat that follows an accepted end-of-packet beat (or the first beat after reset) starts a new packet, even when `s_sop` is low on it.
- R10: Cycles where `s_valid` is low, or where `s_ready` is low, change nothing. The values on the data pins in those cycles do not affect any result.
- R11: A packet of a single beat (`s_sop` and `s_eop` both high) reports that beat's metric at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat can be accepted |
| s_re | input | 16 | Real part, signed |
| s_im | input | 16 | Imaginary part, signed |
| s_sop | input | 1 | First beat of a surface |
| s_eop | input | 1 | Last beat of a surface |
| m_valid | output | 1 | Result beat valid |
| m_ready | input | 1 | Sink accepts the result |
| m_peak | output | 33 | Largest squared magnitude in the surface |
| m_index | output | 12 | Linear position of that sample |

## Verification
The hardest case to reach is an end of packet that arrives while the previous result is still waiting. Here the input has to stall, and then resume in the same cycle the sink drains the old result. The stimulus creates this case by running the sink's ready at a low random rate while short packets stream in back to back. Exact ties are rare with random data, so ties come both from packets of repeated values and from random values drawn from a very narrow range.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int SMP_W_DEF    = 16;
  localparam int SURF_DIM_DEF = 64;

  // Width of re^2 + im^2 for signed inputs of width w, kept one bit wide.
  function automatic int mag_width(input int w);
    return 2 * w + 1;
  endfunction

  // Width of a linear index over a d x d surface.
  function automatic int idx_width(input int d);
    return $clog2(d * d);
  endfunction
endpackage

// File: rtl/cpf_sqmag.sv
module cpf_sqmag #(
  parameter int SMP_W = 16,
  parameter int MAG_W = 33
) (
  input  logic signed [SMP_W-1:0] re,
  input  logic signed [SMP_W-1:0] im,
  output logic        [MAG_W-1:0] mag
);
  localparam int PRD_W = 2 * SMP_W;

  logic signed [PRD_W-1:0] re_sq;
  logic signed [PRD_W-1:0] im_sq;

  always_comb begin
    re_sq = re * re;
    im_sq = im * im;
    mag   = MAG_W'($unsigned(re_sq)) + MAG_W'($unsigned(im_sq));
  end
endmodule

// File: rtl/cpf_tracker.sv
module cpf_tracker #(
  parameter int MAG_W = 33,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sop,
  input  logic             eop,
  input  logic [MAG_W-1:0] mag,
  output logic [MAG_W-1:0] fin_mag,
  output logic [IDX_W-1:0] fin_idx
);
  logic [MAG_W-1:0] best_q;
  logic [IDX_W-1:0] best_idx_q;
  logic [IDX_W-1:0] cnt_q;
  logic             fresh_q;

  logic             first;
  logic             take;
  logic [IDX_W-1:0] cur_idx;

  always_comb begin
    first   = sop | fresh_q;
    cur_idx = first ? '0 : cnt_q;
    take    = first | (mag > best_q);
    fin_mag = take ? mag     : best_q;
    fin_idx = take ? cur_idx : best_idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_q     <= '0;
      best_idx_q <= '0;
      cnt_q      <= '0;
      fresh_q    <= 1'b1;
    end else if (beat) begin
      best_q     <= fin_mag;
      best_idx_q <= fin_idx;
      cnt_q      <= cur_idx + IDX_W'(1);
      fresh_q    <= eop;
    end
  end
endmodule

// File: rtl/cpf_result_reg.sv
module cpf_result_reg #(
  parameter int MAG_W = 33,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAG_W-1:0] ld_mag,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [MAG_W-1:0] out_mag,
  output logic [IDX_W-1:0] out_idx,
  output logic             stall
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_idx   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_mag   <= ld_mag;
      out_idx   <= ld_idx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign stall = out_valid & ~out_ready;
endmodule

// File: rtl/corr_peak_finder.sv
module corr_peak_finder #(
  parameter  int SMP_W    = cpf_pkg::SMP_W_DEF,
  parameter  int SURF_DIM = cpf_pkg::SURF_DIM_DEF,
  localparam int MAG_W    = cpf_pkg::mag_width(SMP_W),
  localparam int IDX_W    = cpf_pkg::idx_width(SURF_DIM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic signed [SMP_W-1:0] s_re,
  input  logic signed [SMP_W-1:0] s_im,
  input  logic                    s_sop,
  input  logic                    s_eop,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic        [MAG_W-1:0] m_peak,
  output logic        [IDX_W-1:0] m_index
);
  logic             stall;
  logic             beat;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] fin_mag;
  logic [IDX_W-1:0] fin_idx;

  assign s_ready = ~stall;
  assign beat    = s_valid & s_ready;

  cpf_sqmag #(.SMP_W(SMP_W), .MAG_W(MAG_W)) u_sqmag (
    .re  (s_re),
    .im  (s_im),
    .mag (mag)
  );

  cpf_tracker #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .sop     (s_sop),
    .eop     (s_eop),
    .mag     (mag),
    .fin_mag (fin_mag),
    .fin_idx (fin_idx)
  );

  cpf_result_reg #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (beat & s_eop),
    .ld_mag    (fin_mag),
    .ld_idx    (fin_idx),
    .out_ready (m_ready),
    .out_valid (m_valid),
    .out_mag   (m_peak),
    .out_idx   (m_index),
    .stall     (stall)
  );
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
  parameter int MAG_W = 33,
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_eop,
  input logic             m_valid,
  input logic             m_ready,
  input logic [MAG_W-1:0] m_peak,
  input logic [IDX_W-1:0] m_index
);
  logic eop_beat;
  assign eop_beat = s_valid & s_ready & s_eop;

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_beat |=> m_valid); // R6

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(eop_beat)); // R6

  AST_HOLD_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_peak) && $stable(m_index))); // R7

  AST_DRAIN_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !eop_beat) |=> !m_valid); // R7

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R8

  AST_OPEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid || m_ready) |-> s_ready); // R8
endmodule

bind corr_peak_finder cpf_checker #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_cpf_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_eop   (s_eop),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_peak  (m_peak),
  .m_index (m_index)
);

// File: tb/corr_peak_finder_tb.sv
module corr_peak_finder_tb;
  localparam int SMP_W = 16;
  localparam int MAG_W = 33;
  localparam int IDX_W = 12;
  localparam int QD    = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                    s_valid = 1'b0;
  logic                    s_ready;
  logic signed [SMP_W-1:0] s_re = '0;
  logic signed [SMP_W-1:0] s_im = '0;
  logic                    s_sop = 1'b0;
  logic                    s_eop = 1'b0;
  logic                    m_valid;
  logic                    m_ready = 1'b0;
  logic [MAG_W-1:0]        m_peak;
  logic [IDX_W-1:0]        m_index;

  corr_peak_finder u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_re(s_re), .s_im(s_im),
    .s_sop(s_sop), .s_eop(s_eop),
    .m_valid(m_valid), .m_ready(m_ready), .m_peak(m_peak), .m_index(m_index)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [MAG_W-1:0] exp_pk [QD];
  logic [IDX_W-1:0] exp_ix [QD];
  string            exp_tag[QD];
  int wr_p = 0;
  int rd_p = 0;

  bit     md_fresh = 1'b1;
  int     md_cnt   = 0;
  longint md_best  = 0;
  int     md_bidx  = 0;
  string  cur_tag  = "R2";
  int     rdy_pct  = 70;
  bit     mon_on   = 1'b0;

  function automatic longint sqm(input int re, input int im);
    longint r = re;
    longint i = im;
    return r * r + i * i;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Called at a negative edge; returns at the negative edge after acceptance.
  task automatic push(input int re, input int im, input bit sop, input bit eop);
    bit     first;
    int     idx;
    longint mg;
    first = sop || md_fresh;
    idx   = first ? 0 : md_cnt;
    mg    = sqm(re, im);
    if (first || mg > md_best) begin
      md_best = mg;
      md_bidx = idx;
    end
    md_cnt   = idx + 1;
    md_fresh = eop;
    if (eop) begin
      exp_pk[wr_p % QD]  = MAG_W'(md_best);
      exp_ix[wr_p % QD]  = IDX_W'(md_bidx);
      exp_tag[wr_p % QD] = cur_tag;
      wr_p++;
    end
    s_valid = 1'b1;
    s_re = SMP_W'(re);
    s_im = SMP_W'(im);
    s_sop = sop;
    s_eop = eop;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_sop = 1'b0;
    s_eop = 1'b0;
    if (eop) check(m_valid === 1'b1, "R6 result one cycle after eop", longint'(m_valid), 1);
  endtask

  // Idle cycles with junk on the data pins (R10).
  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      s_valid = 1'b0;
      s_re = SMP_W'($urandom);
      s_im = SMP_W'($urandom);
      s_sop = 1'($urandom);
      s_eop = 1'($urandom);
      @(negedge clk);
    end
    s_sop = 1'b0;
    s_eop = 1'b0;
  endtask

  // Output monitor and sink.
  initial begin : monitor
    bit               hold = 1'b0;
    logic [MAG_W-1:0] h_pk;
    logic [IDX_W-1:0] h_ix;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (hold) begin
          check(m_valid === 1'b1, "R7 valid held", longint'(m_valid), 1);
          check(m_peak === h_pk, "R7 peak held", longint'(m_peak), longint'(h_pk));
          check(m_index === h_ix, "R7 index held", longint'(m_index), longint'(h_ix));
        end
        m_ready = (($urandom % 100) < rdy_pct);
        if (m_valid && m_ready) begin
          if (rd_p >= wr_p) begin
            check(1'b0, "R6 unexpected result", longint'(m_peak), -1);
          end else begin
            check(m_peak === exp_pk[rd_p % QD], {exp_tag[rd_p % QD], " peak"},
                  longint'(m_peak), longint'(exp_pk[rd_p % QD]));
            check(m_index === exp_ix[rd_p % QD], {exp_tag[rd_p % QD], " index"},
                  longint'(m_index), longint'(exp_ix[rd_p % QD]));
            rd_p++;
          end
        end
        hold = m_valid && !m_ready;
        h_pk = m_peak;
        h_ix = m_index;
        #1;
        check(s_ready === !(m_valid && !m_ready), "R8 ready vs pending result",
              longint'(s_ready), longint'(!(m_valid && !m_ready)));
      end
    end
  end

  initial begin : watchdog
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    summary();
  end

  task automatic rand_packet(input int len, input bit narrow, input bit with_sop, input bit gaps);
    for (int k = 0; k < len; k++) begin
      int re;
      int im;
      if (narrow) begin
        re = int'($urandom % 7) - 3;
        im = int'($urandom % 7) - 3;
      end else begin
        re = int'($signed(16'($urandom)));
        im = int'($signed(16'($urandom)));
      end
      push(re, im, (k == 0) && with_sop, k == len - 1);
      if (gaps && ($urandom % 4 == 0)) gap(int'($urandom % 3) + 1);
    end
  endtask

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(m_valid === 1'b0, "R1 m_valid in reset", longint'(m_valid), 0);
    check(s_ready === 1'b1, "R1 s_ready in reset", longint'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid === 1'b0, "R1 m_valid after reset", longint'(m_valid), 0);
    check(s_ready === 1'b1, "R1 s_ready after reset", longint'(s_ready), 1);
    mon_on = 1'b1;

    cur_tag = "R11 R2 extreme single beat";
    push(-32768, -32768, 1'b1, 1'b1);
    cur_tag = "R11 single beat small";
    push(0, -1, 1'b1, 1'b1);

    cur_tag = "R3 all equal";
    for (int k = 0; k < 8; k++) push(3, -4, k == 0, k == 7);
    cur_tag = "R3 tie keeps earlier";
    push(1, 1, 1, 0); push(2, 0, 0, 0); push(6, 8, 0, 0);
    push(0, 3, 0, 0); push(-8, 6, 0, 0); push(10, 0, 0, 0); push(1, 2, 0, 1);

    cur_tag = "R4 big packet";
    for (int k = 0; k < 4; k++) push(1000, 1000, k == 0, k == 3);
    cur_tag = "R4 first beat loads";
    push(1, 0, 1, 0); push(0, 2, 0, 0); push(1, 1, 0, 1);

    cur_tag = "R9 no sop after eop";
    push(5, 0, 0, 0); push(0, -7, 0, 0); push(2, 2, 0, 1);

    cur_tag = "R10 gaps and junk";
    gap(3); push(4, 4, 1, 0); gap(5); push(-9, 1, 0, 0); gap(2); push(3, 3, 0, 1);

    cur_tag = "R5 position row37 col21";
    for (int k = 0; k < 4096; k++) begin
      if (k == 37 * 64 + 21) push(20000, -20000, 0, 0);
      else push(int'($urandom % 2001) - 1000, int'($urandom % 2001) - 1000, k == 0, k == 4095);
    end

    cur_tag = "R2 R5 full random surface";
    rand_packet(4096, 1'b0, 1'b1, 1'b0);
    rdy_pct = 15;
    cur_tag = "R8 R2 full random slow sink";
    rand_packet(4096, 1'b0, 1'b1, 1'b0);

    for (int p = 0; p < 60; p++) begin
      rdy_pct = (p % 3 == 0) ? 10 : 80;
      cur_tag = (p % 2 == 0) ? "R3 R9 narrow short" : "R2 R10 random short";
      rand_packet(int'($urandom % 40) + 1, p % 2 == 0, ($urandom % 5) != 0, 1'b1);
    end

    cur_tag = "R8 back to back singles";
    rdy_pct = 20;
    for (int p = 0; p < 30; p++) push(p * 7 - 100, 50 - p, 1'b1, 1'b1);

    rdy_pct = 100;
    for (int w = 0; w < 2000 && rd_p < wr_p; w++) @(negedge clk);
    check(rd_p == wr_p, "R6 all results delivered", rd_p, wr_p);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule